// File: doc/BRIEF.md
# Dual-Pipeline Priority Issue Selector

This block is the issue stage of an in-order multithreaded core with two execution pipelines: an integer pipeline and an address pipeline that also carries loads and stores. Each of eight thread slots offers the two oldest entries of its instruction window. Each entry has a ready flag and a two-bit kind. An external controller supplies a priority level and an active flag for every slot. Every cycle the block sends at most one instruction to each pipeline and reports which slot fed it.

The highest-priority eligible slot chooses first. It issues its oldest entry and may also issue its second entry in the same cycle, but only when an integer instruction is directly followed by an address-pipeline instruction. If that slot leaves a pipeline unused, the pipeline is filled with the oldest entry of the best lower-ranked slot whose instruction fits it. A slot that issues a branch stops issuing until the branch is reported resolved.

When the dominant slot issues a load or store, the block raises an early notice to the memory controller in the same cycle. The dominant slot is the highest-priority active slot.

Per-slot branch state machine: states `S_RUN` (may issue) and `S_HOLD` (waiting for a branch). Transition `take_branch` goes from `S_RUN` to `S_HOLD` when the slot's branch issues on the integer pipeline. Transition `resolve` goes from `S_HOLD` to `S_RUN` at the clock edge where that slot's resolve bit is high.

Top module: `smt_issue_sel`

## Requirements
- R1: After reset every slot is in `S_RUN`, so any active slot with a ready oldest entry can issue in the first cycle after reset. With no active slot, both pipeline valids are 0.
- R2: A slot whose active bit is 0, or whose oldest entry is not ready, is never selected for either pipeline.
- R3: Within a slot, issue is in order: the second entry is issued only together with the oldest entry, and never when the oldest entry is not ready.
- R4: Kind codes are 0 integer, 1 address arithmetic, 2 load/store and 3 branch. Kinds 0 and 3 go to the integer pipeline, and kinds 1 and 2 go to the address pipeline. A slot issues two entries (`addr_second`=1) only when its oldest entry has kind 0 and its second entry is ready with kind 1 or 2.
- R5: The winner is the eligible slot with the numerically largest priority. Whenever any slot is eligible, at least one pipeline issues.
- R6: When the winner uses only one pipeline, the other pipeline takes the oldest entry of the highest-ranked other eligible slot whose oldest entry fits that pipeline. A filler slot issues only one entry.
- R7: When the dominant slot is eligible, it is the winner, and its oldest entry issues regardless of the other slots.
- R8: After a slot issues a branch (kind 3), it issues nothing until the clock edge after its `br_done` bit is sampled high.
- R9: `mem_announce` is 1 in exactly the cycles where the dominant slot issues a kind-2 entry, whether as its oldest or its second entry.
- R10: Between slots of equal priority, the lower slot index ranks higher.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| slot_active | input | 8 | Slot may be scheduled |
| slot_prio | input | 24 | 3-bit priority per slot, slot i at bits [3i+2:3i] |
| h0_ok | input | 8 | Oldest entry present and operands ready |
| h0_kind | input | 16 | Kind of oldest entry, slot i at bits [2i+1:2i] |
| h1_ok | input | 8 | Second entry present and operands ready |
| h1_kind | input | 16 | Kind of second entry |
| br_done | input | 8 | Branch of slot resolved |
| int_vld | output | 1 | Integer pipeline issues |
| int_slot | output | 3 | Slot feeding the integer pipeline |
| addr_vld | output | 1 | Address pipeline issues |
| addr_slot | output | 3 | Slot feeding the address pipeline |
| addr_second | output | 1 | Address pipeline takes the winner's second entry |
| mem_announce | output | 1 | Dominant slot issues a load/store |

## Verification
Two functions can fall in the same cycle: the dominant slot issuing a load/store, which raises the notice, and a lower slot filling the integer pipeline beside it. The other overlap is a dual issue that places a load/store second. Directed cycles build each case: one puts a high-priority load/store next to a lower integer slot, and another puts a high-priority integer+load pair next to a lower address slot. Each is judged by checking both pipeline slots, the second-entry flag and the notice against a bench model. Random cycles with mixed kinds, priorities and ready flags revisit these overlaps many times, including cycles where the dominant slot is not ready and the notice must stay low.

// File: rtl/smt_issue_pkg.sv
package smt_issue_pkg;
    typedef enum logic [1:0] {
        K_INT = 2'd0,
        K_ADR = 2'd1,
        K_MEM = 2'd2,
        K_BR  = 2'd3
    } kind_e;

    typedef enum logic {
        S_RUN  = 1'b0,
        S_HOLD = 1'b1
    } slot_st_e;
endpackage

// File: rtl/slot_branch_fsm.sv
module slot_branch_fsm
    import smt_issue_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic take_branch,
    input  logic resolve,
    output logic held
);
    slot_st_e st, st_nx;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= S_RUN;
        else        st <= st_nx;
    end

    always_comb begin
        st_nx = st;
        unique case (st)
            S_RUN:  if (take_branch) st_nx = S_HOLD;
            S_HOLD: if (resolve)     st_nx = S_RUN;
            default: st_nx = S_RUN;
        endcase
    end

    assign held = (st == S_HOLD);

    // R8: a branch issued from a running slot always leaves it blocked next cycle
    a_r8_branch_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        (!held && take_branch) |=> held);
endmodule

// File: rtl/prio_pick.sv
module prio_pick #(
    parameter int N  = 8,
    parameter int PW = 3,
    localparam int SW = $clog2(N)
) (
    input  logic [N-1:0]    req,
    input  logic [N*PW-1:0] prio,
    output logic            vld,
    output logic [SW-1:0]   idx
);
    logic [PW-1:0] best;

    always_comb begin
        vld  = 1'b0;
        idx  = '0;
        best = '0;
        for (int i = 0; i < N; i++) begin
            if (req[i] && (!vld || prio[i*PW +: PW] > best)) begin
                vld  = 1'b1;
                idx  = SW'(i);
                best = prio[i*PW +: PW];
            end
        end
    end

    // R2/R10: a reported winner was requesting
    a_r2_pick_requested: assert final (!vld || req[idx]);
endmodule

// File: rtl/smt_issue_sel.sv
module smt_issue_sel
    import smt_issue_pkg::*;
#(
    parameter int N  = 8,
    parameter int PW = 3,
    localparam int SW = $clog2(N)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [N-1:0]    slot_active,
    input  logic [N*PW-1:0] slot_prio,
    input  logic [N-1:0]    h0_ok,
    input  logic [2*N-1:0]  h0_kind,
    input  logic [N-1:0]    h1_ok,
    input  logic [2*N-1:0]  h1_kind,
    input  logic [N-1:0]    br_done,
    output logic            int_vld,
    output logic [SW-1:0]   int_slot,
    output logic            addr_vld,
    output logic [SW-1:0]   addr_slot,
    output logic            addr_second,
    output logic            mem_announce
);
    logic [N-1:0] held, elig, to_int, to_adr, take_br;
    logic [N-1:0] fi_req, fa_req;
    logic         dom_vld, w_vld, fi_vld, fa_vld;
    logic [SW-1:0] dom_idx, w_idx, fi_idx, fa_idx;
    kind_e        wk0, wk1;
    logic         w_int, w_dual, w_adr;

    for (genvar g = 0; g < N; g++) begin : g_slot
        assign to_int[g]  = (h0_kind[2*g +: 2] == K_INT) || (h0_kind[2*g +: 2] == K_BR);
        assign to_adr[g]  = !to_int[g];
        assign elig[g]    = slot_active[g] && h0_ok[g] && !held[g];
        assign take_br[g] = int_vld && (int_slot == SW'(g)) && (h0_kind[2*g +: 2] == K_BR);

        slot_branch_fsm u_fsm (
            .clk         (clk),
            .rst_n       (rst_n),
            .take_branch (take_br[g]),
            .resolve     (br_done[g]),
            .held        (held[g])
        );
    end

    prio_pick #(.N(N), .PW(PW)) u_dom (.req(slot_active), .prio(slot_prio), .vld(dom_vld), .idx(dom_idx));
    prio_pick #(.N(N), .PW(PW)) u_win (.req(elig),        .prio(slot_prio), .vld(w_vld),   .idx(w_idx));
    prio_pick #(.N(N), .PW(PW)) u_fi  (.req(fi_req),      .prio(slot_prio), .vld(fi_vld),  .idx(fi_idx));
    prio_pick #(.N(N), .PW(PW)) u_fa  (.req(fa_req),      .prio(slot_prio), .vld(fa_vld),  .idx(fa_idx));

    always_comb begin
        wk0    = kind_e'(h0_kind[{w_idx, 1'b0} +: 2]);
        wk1    = kind_e'(h1_kind[{w_idx, 1'b0} +: 2]);
        w_int  = (wk0 == K_INT) || (wk0 == K_BR);
        w_dual = w_vld && (wk0 == K_INT) && h1_ok[w_idx] && ((wk1 == K_ADR) || (wk1 == K_MEM));
        w_adr  = w_vld && (!w_int || w_dual);
        fi_req = (w_vld && !w_int)          ? (elig & to_int & ~(N'(1) << w_idx)) : '0;
        fa_req = (w_vld && w_int && !w_dual) ? (elig & to_adr & ~(N'(1) << w_idx)) : '0;
    end

    always_comb begin
        int_vld      = (w_vld && w_int) || fi_vld;
        int_slot     = (w_vld && w_int) ? w_idx : fi_idx;
        addr_vld     = w_adr || fa_vld;
        addr_slot    = w_adr ? w_idx : fa_idx;
        addr_second  = w_dual;
        mem_announce = dom_vld && w_vld && (dom_idx == w_idx) &&
                       ((wk0 == K_MEM) || (w_dual && wk1 == K_MEM));
    end

    // R2: only active, ready, unblocked slots reach a pipeline
    a_r2_int_legal: assert property (@(posedge clk) disable iff (!rst_n)
        int_vld |-> (slot_active[int_slot] && h0_ok[int_slot]));
    a_r2_addr_legal: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_vld && !addr_second) |-> (slot_active[addr_slot] && h0_ok[addr_slot]));
    // R3/R4: second entry only beside its own oldest integer entry
    a_r3_in_order: assert property (@(posedge clk) disable iff (!rst_n)
        addr_second |-> (int_vld && int_slot == addr_slot && h0_ok[addr_slot] && h1_ok[addr_slot]
                         && h0_kind[{addr_slot, 1'b0} +: 2] == K_INT));
    a_r4_same_slot_is_dual: assert property (@(posedge clk) disable iff (!rst_n)
        (int_vld && addr_vld && int_slot == addr_slot) |-> addr_second);
    // R5: something issues whenever a slot is eligible
    a_r5_work_conserving: assert property (@(posedge clk) disable iff (!rst_n)
        (|elig) |-> (int_vld || addr_vld));
    // R7: an eligible dominant slot always issues
    a_r7_dominant_issues: assert property (@(posedge clk) disable iff (!rst_n)
        (dom_vld && elig[dom_idx]) |-> ((int_vld && int_slot == dom_idx) ||
                                        (addr_vld && addr_slot == dom_idx)));
    // R8: the slot that issued a branch is silent in the next cycle
    a_r8_no_issue_after_branch: assert property (@(posedge clk) disable iff (!rst_n)
        (int_vld && h0_kind[{int_slot, 1'b0} +: 2] == K_BR) |=>
        !((int_vld && int_slot == $past(int_slot)) || (addr_vld && addr_slot == $past(int_slot))));
    // R9: notice only with an address-pipe issue
    a_r9_announce_with_issue: assert property (@(posedge clk) disable iff (!rst_n)
        mem_announce |-> addr_vld);
endmodule

// File: tb/smt_issue_sel_test.sv
module smt_issue_sel_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  act = '0, ok0 = '0, ok1 = '0, brd = '0;
    logic [23:0] pr = '0;
    logic [15:0] k0 = '0, k1 = '0;
    logic        int_vld, addr_vld, addr_second, mem_announce;
    logic [2:0]  int_slot, addr_slot;

    int n_run = 0, n_fail = 0;
    logic [7:0] mhold = '0;
    logic e_iv, e_av, e_sec, e_ann;
    logic [2:0] e_is, e_as;

    always #4 clk = ~clk;

    smt_issue_sel uut (
        .clk(clk), .rst_n(rst_n), .slot_active(act), .slot_prio(pr),
        .h0_ok(ok0), .h0_kind(k0), .h1_ok(ok1), .h1_kind(k1), .br_done(brd),
        .int_vld(int_vld), .int_slot(int_slot), .addr_vld(addr_vld),
        .addr_slot(addr_slot), .addr_second(addr_second), .mem_announce(mem_announce)
    );

    function automatic logic [3:0] bpick(input logic [7:0] m);
        logic v = 1'b0; logic [2:0] ix = '0; logic [2:0] b = '0;
        for (int i = 0; i < 8; i++)
            if (m[i] && (!v || pr[i*3 +: 3] > b)) begin
                v = 1'b1; ix = 3'(i); b = pr[i*3 +: 3];
            end
        return {v, ix};
    endfunction

    function automatic logic is_int(input logic [1:0] k);
        return (k == 2'd0) || (k == 2'd3);
    endfunction

    task automatic model();
        logic [7:0] el, im, fm;
        logic [3:0] d, w, f;
        logic [1:0] a0, a1;
        logic wi, du;
        el = act & ok0 & ~mhold;
        im = '0;
        for (int i = 0; i < 8; i++) im[i] = is_int(k0[2*i +: 2]);
        d = bpick(act); w = bpick(el);
        a0 = k0[2*w[2:0] +: 2]; a1 = k1[2*w[2:0] +: 2];
        wi = is_int(a0);
        du = w[3] && a0 == 2'd0 && ok1[w[2:0]] && (a1 == 2'd1 || a1 == 2'd2);
        fm = el & ~(8'd1 << w[2:0]);
        e_iv = 0; e_is = 0; e_av = 0; e_as = 0; e_sec = du; e_ann = 0;
        if (w[3]) begin
            if (wi) begin
                e_iv = 1; e_is = w[2:0];
                if (du) begin e_av = 1; e_as = w[2:0]; end
                else begin f = bpick(fm & ~im); e_av = f[3]; e_as = f[3] ? f[2:0] : 3'd0; end
            end else begin
                e_av = 1; e_as = w[2:0];
                f = bpick(fm & im); e_iv = f[3]; e_is = f[3] ? f[2:0] : 3'd0;
            end
            e_ann = d[3] && d[2:0] == w[2:0] && (a0 == 2'd2 || (du && a1 == 2'd2));
        end
    endtask

    task automatic chk(input string tag, input string what, input logic [3:0] got, input logic [3:0] exp);
        n_run++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s %s: got %0h expected %0h", tag, what, got, exp);
        end
    endtask

    // checks one cycle; caller has set inputs just after the falling edge
    task automatic cycle(input string tag);
        #2;
        model();
        chk(tag, "int_vld (R5)", {3'd0, int_vld}, {3'd0, e_iv});
        if (e_iv) chk(tag, "int_slot (R5/R6)", {1'b0, int_slot}, {1'b0, e_is});
        chk(tag, "addr_vld (R6)", {3'd0, addr_vld}, {3'd0, e_av});
        if (e_av) chk(tag, "addr_slot (R6)", {1'b0, addr_slot}, {1'b0, e_as});
        chk(tag, "addr_second (R4)", {3'd0, addr_second}, {3'd0, e_sec});
        chk(tag, "mem_announce (R9)", {3'd0, mem_announce}, {3'd0, e_ann});
        for (int i = 0; i < 8; i++) begin
            if (mhold[i]) begin if (brd[i]) mhold[i] = 1'b0; end
            else if (e_iv && e_is == 3'(i) && k0[2*i +: 2] == 2'd3) mhold[i] = 1'b1;
        end
        @(negedge clk);
    endtask

    task automatic clear();
        act = '0; ok0 = '0; ok1 = '0; brd = '0; pr = '0; k0 = '0; k1 = '0;
    endtask

    task automatic setslot(input int s, input logic [2:0] p, input logic [1:0] a,
                           input logic o0, input logic [1:0] b, input logic o1);
        act[s] = 1'b1; pr[s*3 +: 3] = p; k0[2*s +: 2] = a; ok0[s] = o0;
        k1[2*s +: 2] = b; ok1[s] = o1;
    endtask

    initial begin
        #(8 * 200000);
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: idle after reset, then any slot issues at once
        clear(); cycle("R1 idle");
        clear(); setslot(5, 3'd1, 2'd0, 1, 2'd0, 0); cycle("R1 first issue");
        // R10: equal priority, lower index wins
        clear(); setslot(6, 3'd4, 2'd0, 1, 2'd0, 0); setslot(1, 3'd4, 2'd0, 1, 2'd0, 0); cycle("R10 tie");
        // R4 + R9: dual issue with load second, dominant announces
        clear(); setslot(3, 3'd6, 2'd0, 1, 2'd2, 1); setslot(0, 3'd2, 2'd1, 1, 2'd0, 0); cycle("R4 dual load");
        // R6: no pair, address pipe filled from lower slot
        clear(); setslot(3, 3'd6, 2'd0, 1, 2'd0, 1); setslot(0, 3'd2, 2'd1, 1, 2'd0, 0); cycle("R6 fill addr");
        // R9 + R6 same cycle: dominant load, integer pipe filled below
        clear(); setslot(2, 3'd7, 2'd2, 1, 2'd0, 0); setslot(4, 3'd1, 2'd0, 1, 2'd0, 0); cycle("R9 load+fill");
        // R2: suspended high-priority slot skipped
        clear(); setslot(7, 3'd7, 2'd2, 1, 2'd0, 0); act[7] = 1'b0; setslot(1, 3'd1, 2'd0, 1, 2'd0, 0); cycle("R2 suspended");
        // R7/R9: dominant not ready, next slot's load gives no notice
        clear(); setslot(7, 3'd7, 2'd2, 0, 2'd0, 0); setslot(1, 3'd1, 2'd2, 1, 2'd0, 0); cycle("R7 dom idle");
        // R3: oldest not ready, second ready -> nothing from that slot
        clear(); setslot(6, 3'd5, 2'd0, 0, 2'd1, 1); cycle("R3 in order");
        // R8: branch blocks until resolve
        clear(); setslot(2, 3'd3, 2'd3, 1, 2'd0, 0); cycle("R8 branch");
        cycle("R8 held");
        brd[2] = 1'b1; cycle("R8 resolve cycle");
        brd[2] = 1'b0; cycle("R8 released");
        // random mix
        for (int n = 0; n < 3000; n++) begin
            act = 8'($urandom); ok0 = 8'($urandom) | 8'($urandom); ok1 = 8'($urandom);
            pr = 24'($urandom); k0 = 16'($urandom); k1 = 16'($urandom);
            brd = 8'($urandom) & 8'($urandom);
            cycle("R5/R6/R7 random");
        end
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule